// File: doc/BRIEF.md
# Multi-Core Power Sequencer

This block switches processor cores on and off, one at a time, inside a small system of `N_CLUSTERS` clusters with `N_CORES` cores each. It drives six controls for every core: an 8-bit power clamp (`0xFF` means fully unpowered and `0x00` means fully powered), an output isolation clamp, an active-low power-on reset, an active-low core reset, a 64-bit boot-mode select and a debug power-up flag. A request names a cluster, a core and a command. The block accepts it only while it is idle. It then steps through a fixed ordering of those controls and holds each step for a set number of clock cycles.

The power-up sequence releases the clamp gradually, as a thermometer code that falls in five steps, and then waits a settle time before isolation and the resets are released. The power-down sequence removes power in one step. A third command powers off every core except the one that made the request, visiting the cores in ascending order. `busy_o` is high for the whole length of a sequence. `done_o` pulses when a sequence finishes. `err_o` pulses when a request is rejected.

Top module: `core_power_seq`

## Requirements
- R1: After reset, flat core 0 (cluster 0, core 0) is powered and running: clamp `0x00`, isolation 0, power-on reset and core reset both high (released), boot-mode 1, debug flag 1. Every other core has clamp `0xFF`, isolation 1, both resets low, boot-mode 0 and debug flag 0. `busy_o`, `done_o` and `err_o` are low.
- R2: Command 1 (power on) applies one action per step, in this order:
  - core reset low;
  - power-on reset low;
  - boot-mode 1;
  - the clamp release (R3);
  - isolation 0;
  - power-on reset high;
  - core reset high;
  - debug flag 1.

  Each step lasts `STEP_CYCLES` cycles. A step's action is visible on the outputs one cycle after the step is entered. The first step is entered on the accepting clock edge.
- R3: The clamp release writes `0xFE`, `0xF8`, `0xE0`, `0x80` and then `0x00`, each held for `STEP_CYCLES` cycles, and then waits `SETTLE_CYCLES` cycles. A clamp output is always a thermometer code: ones in its upper bits and zeros below.
- R4: A power-on request for a core whose clamp is already `0x00` skips both the clamp stepping and the settle wait.
- R5: Command 0 (power off) applies these actions, each step lasting `STEP_CYCLES` cycles:
  - debug flag 0;
  - isolation 1;
  - power-on reset low;
  - clamp `0xFF`.

  Core reset and boot-mode are left unchanged. The clamp changes only while the power-on reset is low.
- R6: A power-off request for a core whose clamp is already `0xFF` omits the clamp step, so the sequence is one step shorter.
- R7: Core 0 of any cluster is never isolated by power-off. Its isolation step is omitted and its isolation output keeps its value.
- R8: Command 2 (power off others) scans the flat indices from 0 upward, spending one cycle per index. It runs the R5 sequence on every index except the requester's own flat index (`cluster*N_CORES+core`). The requester is left untouched.
- R9: `busy_o` is high from the cycle after acceptance until the sequence ends. A request presented while `busy_o` is high is ignored.
- R10: `done_o` is a single-cycle pulse in the first cycle after the final step ends. In that same cycle `busy_o` is already low.
- R11: A request with core index ≥ `N_CORES`, cluster index ≥ `N_CLUSTERS` or command 3 is ignored. `err_o` pulses for one cycle on the next cycle and `busy_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe, sampled while idle |
| req_cmd_i | input | 2 | 0 off, 1 on, 2 off others, 3 reserved |
| req_cluster_i | input | CLW | Cluster index |
| req_core_i | input | COW | Core index within the cluster |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse at the end of a sequence |
| err_o | output | 1 | One-cycle pulse for a rejected request |
| clamp_o | output | 8*NCPU | Power clamp of flat core k at bits [8k+7:8k] |
| iso_o | output | NCPU | Output isolation per flat core |
| por_no | output | NCPU | Power-on reset per flat core, active low |
| core_rst_no | output | NCPU | Core reset per flat core, active low |
| boot64_o | output | NCPU | 64-bit boot-mode select per flat core |
| dbg_pwrup_o | output | NCPU | Debug power-up flag per flat core |

## Verification
The bench builds the block with 2 clusters of 3 cores.

Three cores per cluster lets the 2-bit core field carry the out-of-range value 3. It also makes flat index 3 a core 0 that is not the boot core, so the no-isolation rule can be seen on a core that powers off.

`STEP_CYCLES` of 2 and `SETTLE_CYCLES` of 5 keep each sequence under about 60 cycles. Many random requests and full per-cycle traces of single-core sequences therefore fit in a short run.

// File: rtl/cps_pkg.sv
package cps_pkg;
  typedef enum logic [1:0] {CMD_OFF = 2'd0, CMD_ON = 2'd1, CMD_OFF_OTHERS = 2'd2, CMD_RSVD = 2'd3} cmd_e;

  typedef enum logic [3:0] {
    OP_NONE, OP_RST_SET, OP_POR_SET, OP_BOOT64, OP_CLAMP, OP_ISO_CLR,
    OP_POR_CLR, OP_RST_CLR, OP_DBG_SET, OP_DBG_CLR, OP_ISO_SET
  } op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_ON_RST, S_ON_POR, S_ON_BOOT, S_ON_CLAMP, S_ON_SETTLE, S_ON_ISO,
    S_ON_PORREL, S_ON_RSTREL, S_ON_DBG, S_OFF_DBG, S_OFF_ISO, S_OFF_POR,
    S_OFF_PWR, S_SCAN
  } state_e;

  // graded release: thermometer code shrinking toward zero
  function automatic logic [7:0] clamp_step(input logic [2:0] idx);
    case (idx)
      3'd0:    return 8'hFE;
      3'd1:    return 8'hF8;
      3'd2:    return 8'hE0;
      3'd3:    return 8'h80;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/cps_core_ctl.sv
module cps_core_ctl
  import cps_pkg::*;
#(
  parameter bit BOOT_CORE = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sel_i,
  input  op_e        op_i,
  input  logic [7:0] clamp_val_i,
  output logic [7:0] clamp_o,
  output logic       iso_o,
  output logic       por_no,
  output logic       rst_no,
  output logic       boot64_o,
  output logic       dbg_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clamp_o  <= BOOT_CORE ? 8'h00 : 8'hFF;
      iso_o    <= !BOOT_CORE;
      por_no   <= BOOT_CORE;
      rst_no   <= BOOT_CORE;
      boot64_o <= BOOT_CORE;
      dbg_o    <= BOOT_CORE;
    end else if (sel_i) begin
      case (op_i)
        OP_RST_SET: rst_no   <= 1'b0;
        OP_RST_CLR: rst_no   <= 1'b1;
        OP_POR_SET: por_no   <= 1'b0;
        OP_POR_CLR: por_no   <= 1'b1;
        OP_BOOT64:  boot64_o <= 1'b1;
        OP_CLAMP:   clamp_o  <= clamp_val_i;
        OP_ISO_SET: iso_o    <= 1'b1;
        OP_ISO_CLR: iso_o    <= 1'b0;
        OP_DBG_SET: dbg_o    <= 1'b1;
        OP_DBG_CLR: dbg_o    <= 1'b0;
        default: ;
      endcase
    end
  end

  assert_clamp_thermo_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(clamp_o ^ {clamp_o[6:0], 1'b0}));

  assert_clamp_in_por_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(clamp_o) |-> !por_no);

  assert_dbg_last_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dbg_o) |-> (clamp_o == 8'h00 && !iso_o && por_no && rst_no && boot64_o));
endmodule

// File: rtl/cps_fsm.sv
module cps_fsm
  import cps_pkg::*;
#(
  parameter int N_CLUSTERS    = 2,
  parameter int N_CORES       = 4,
  parameter int STEP_CYCLES   = 4,
  parameter int SETTLE_CYCLES = 125,
  localparam int NCPU   = N_CLUSTERS * N_CORES,
  localparam int CLW    = (N_CLUSTERS > 1) ? $clog2(N_CLUSTERS) : 1,
  localparam int COW    = (N_CORES > 1) ? $clog2(N_CORES) : 1,
  localparam int IDXW   = (NCPU > 1) ? $clog2(NCPU) : 1,
  localparam int MAXLEN = (STEP_CYCLES > SETTLE_CYCLES) ? STEP_CYCLES : SETTLE_CYCLES,
  localparam int CW     = $clog2(MAXLEN + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  input  logic [1:0]      req_cmd_i,
  input  logic [CLW-1:0]  req_cluster_i,
  input  logic [COW-1:0]  req_core_i,
  input  logic [7:0]      tgt_clamp_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            err_o,
  output op_e             op_o,
  output logic [IDXW-1:0] tgt_o,
  output logic [7:0]      clamp_val_o
);
  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(NCPU - 1);

  state_e          st;
  logic [CW-1:0]   cnt;
  logic [2:0]      step_q;
  logic [IDXW-1:0] self_q;
  logic            others_q;

  logic            req_ok, timed, last, clamp_zero, clamp_ff, tgt_core0, on_fin, off_fin;
  logic [IDXW-1:0] req_idx;
  int              len;

  assign req_ok  = (int'(req_cluster_i) < N_CLUSTERS) && (int'(req_core_i) < N_CORES) &&
                   (req_cmd_i != CMD_RSVD);
  assign req_idx = IDXW'(int'(req_cluster_i) * N_CORES + int'(req_core_i));
  assign len        = (st == S_ON_SETTLE) ? SETTLE_CYCLES : STEP_CYCLES;
  assign timed      = (st != S_IDLE) && (st != S_SCAN);
  assign last       = (cnt == CW'(len - 1));
  assign clamp_zero = (tgt_clamp_i == 8'h00);
  assign clamp_ff   = (tgt_clamp_i == 8'hFF);
  assign tgt_core0  = ((int'(tgt_o) % N_CORES) == 0);
  assign on_fin     = (st == S_ON_DBG) && last;
  assign off_fin    = last && (((st == S_OFF_POR) && clamp_ff) || (st == S_OFF_PWR));
  assign busy_o     = (st != S_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st       <= S_IDLE;
      cnt      <= '0;
      step_q   <= '0;
      tgt_o    <= '0;
      self_q   <= '0;
      others_q <= 1'b0;
      done_o   <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      if (timed) cnt <= last ? '0 : cnt + 1'b1;
      case (st)
        S_IDLE: if (req_valid_i) begin
          if (!req_ok) err_o <= 1'b1;
          else begin
            tgt_o    <= req_idx;
            others_q <= 1'b0;
            case (req_cmd_i)
              CMD_ON:  st <= S_ON_RST;
              CMD_OFF: st <= S_OFF_DBG;
              default: begin
                self_q   <= req_idx;
                tgt_o    <= '0;
                others_q <= 1'b1;
                st       <= S_SCAN;
              end
            endcase
          end
        end
        S_ON_RST:    if (last) st <= S_ON_POR;
        S_ON_POR:    if (last) st <= S_ON_BOOT;
        S_ON_BOOT:   if (last) begin
          step_q <= '0;
          st     <= clamp_zero ? S_ON_ISO : S_ON_CLAMP;
        end
        S_ON_CLAMP:  if (last) begin
          if (step_q == 3'd4) st <= S_ON_SETTLE;
          else step_q <= step_q + 3'd1;
        end
        S_ON_SETTLE: if (last) st <= S_ON_ISO;
        S_ON_ISO:    if (last) st <= S_ON_PORREL;
        S_ON_PORREL: if (last) st <= S_ON_RSTREL;
        S_ON_RSTREL: if (last) st <= S_ON_DBG;
        S_ON_DBG:    ;
        S_OFF_DBG:   if (last) st <= tgt_core0 ? S_OFF_POR : S_OFF_ISO;
        S_OFF_ISO:   if (last) st <= S_OFF_POR;
        S_OFF_POR:   if (last && !clamp_ff) st <= S_OFF_PWR;
        S_OFF_PWR:   ;
        S_SCAN: begin
          if (tgt_o != self_q) st <= S_OFF_DBG;
          else if (tgt_o == LAST_IDX) begin
            st     <= S_IDLE;
            done_o <= 1'b1;
          end else tgt_o <= tgt_o + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
      if (on_fin || (off_fin && !(others_q && tgt_o != LAST_IDX))) begin
        st     <= S_IDLE;
        done_o <= 1'b1;
      end else if (off_fin) begin
        tgt_o <= tgt_o + 1'b1;
        st    <= S_SCAN;
      end
    end
  end

  // one action per step, issued on the step's first cycle
  always_comb begin
    op_o        = OP_NONE;
    clamp_val_o = 8'hFF;
    if (cnt == '0) begin
      case (st)
        S_ON_RST:    op_o = OP_RST_SET;
        S_ON_POR:    op_o = OP_POR_SET;
        S_ON_BOOT:   op_o = OP_BOOT64;
        S_ON_CLAMP:  begin op_o = OP_CLAMP; clamp_val_o = clamp_step(step_q); end
        S_ON_ISO:    op_o = OP_ISO_CLR;
        S_ON_PORREL: op_o = OP_POR_CLR;
        S_ON_RSTREL: op_o = OP_RST_CLR;
        S_ON_DBG:    op_o = OP_DBG_SET;
        S_OFF_DBG:   op_o = OP_DBG_CLR;
        S_OFF_ISO:   op_o = OP_ISO_SET;
        S_OFF_POR:   op_o = OP_POR_SET;
        S_OFF_PWR:   op_o = OP_CLAMP;
        default:     op_o = OP_NONE;
      endcase
    end
  end

  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_err_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !busy_o);

  assert_no_retarget_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) && !others_q) |-> $stable(tgt_o));

  assert_skip_self_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (others_q && op_o != OP_NONE) |-> (tgt_o != self_q));

  assert_no_iso_core0_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_o == OP_ISO_SET) |-> !tgt_core0);
endmodule

// File: rtl/core_power_seq.sv
module core_power_seq
  import cps_pkg::*;
#(
  parameter int N_CLUSTERS    = 2,
  parameter int N_CORES       = 4,
  parameter int STEP_CYCLES   = 4,
  parameter int SETTLE_CYCLES = 125,
  localparam int NCPU = N_CLUSTERS * N_CORES,
  localparam int CLW  = (N_CLUSTERS > 1) ? $clog2(N_CLUSTERS) : 1,
  localparam int COW  = (N_CORES > 1) ? $clog2(N_CORES) : 1,
  localparam int IDXW = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        req_cmd_i,
  input  logic [CLW-1:0]    req_cluster_i,
  input  logic [COW-1:0]    req_core_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [8*NCPU-1:0] clamp_o,
  output logic [NCPU-1:0]   iso_o,
  output logic [NCPU-1:0]   por_no,
  output logic [NCPU-1:0]   core_rst_no,
  output logic [NCPU-1:0]   boot64_o,
  output logic [NCPU-1:0]   dbg_pwrup_o
);
  op_e             op;
  logic [IDXW-1:0] tgt;
  logic [7:0]      clamp_val, tgt_clamp;

  assign tgt_clamp = clamp_o[8*tgt +: 8];

  cps_fsm #(
    .N_CLUSTERS(N_CLUSTERS), .N_CORES(N_CORES),
    .STEP_CYCLES(STEP_CYCLES), .SETTLE_CYCLES(SETTLE_CYCLES)
  ) u_fsm (
    .clk_i, .rst_ni, .req_valid_i, .req_cmd_i, .req_cluster_i, .req_core_i,
    .tgt_clamp_i(tgt_clamp), .busy_o, .done_o, .err_o,
    .op_o(op), .tgt_o(tgt), .clamp_val_o(clamp_val)
  );

  for (genvar k = 0; k < NCPU; k++) begin : g_core
    cps_core_ctl #(.BOOT_CORE(k == 0)) u_ctl (
      .clk_i, .rst_ni,
      .sel_i(tgt == IDXW'(k)), .op_i(op), .clamp_val_i(clamp_val),
      .clamp_o(clamp_o[8*k +: 8]), .iso_o(iso_o[k]), .por_no(por_no[k]),
      .rst_no(core_rst_no[k]), .boot64_o(boot64_o[k]), .dbg_o(dbg_pwrup_o[k])
    );
  end
endmodule

// File: tb/core_power_seq_test.sv
module core_power_seq_test;
  localparam int NCL = 2, NCO = 3, STEP = 2, SETTLE = 5, NCPU = NCL * NCO;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, req_valid, busy, done, err;
  logic [1:0] req_cmd, req_core;
  logic [0:0] req_cluster;
  logic [8*NCPU-1:0] clamp;
  logic [NCPU-1:0] iso, por_n, rst_core_n, boot, dbg;

  core_power_seq #(.N_CLUSTERS(NCL), .N_CORES(NCO), .STEP_CYCLES(STEP), .SETTLE_CYCLES(SETTLE)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_cmd_i(req_cmd),
    .req_cluster_i(req_cluster), .req_core_i(req_core), .busy_o(busy), .done_o(done),
    .err_o(err), .clamp_o(clamp), .iso_o(iso), .por_no(por_n), .core_rst_no(rst_core_n),
    .boot64_o(boot), .dbg_pwrup_o(dbg)
  );

  int checks = 0, errors = 0;
  // model snapshot per core: {clamp[7:0], iso, por_n, rst_n, boot, dbg}
  logic [12:0] model [NCPU];

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [12:0] dut_snap(input int k);
    return {clamp[8*k +: 8], iso[k], por_n[k], rst_core_n[k], boot[k], dbg[k]};
  endfunction

  function automatic logic [7:0] step_val(input int j);
    case (j)
      0: return 8'hFE; 1: return 8'hF8; 2: return 8'hE0; 3: return 8'h80; default: return 8'h00;
    endcase
  endfunction

  function automatic int on_dur(input logic [12:0] init);
    return ((init[12:5] == 8'h00) ? 3 * STEP : 8 * STEP + SETTLE) + 4 * STEP;
  endfunction

  function automatic int off_dur(input logic [12:0] init, input int k);
    return STEP + ((k % NCO == 0) ? 0 : STEP) + STEP + ((init[12:5] == 8'hFF) ? 0 : STEP);
  endfunction

  function automatic logic [12:0] on_exp(input logic [12:0] init, input int n);
    logic [12:0] v = init;
    bit skip = (init[12:5] == 8'h00);
    int base = skip ? 3 * STEP : 8 * STEP + SETTLE;
    if (n >= 2) v[2] = 1'b0;
    if (n >= STEP + 2) v[3] = 1'b0;
    if (n >= 2 * STEP + 2) v[1] = 1'b1;
    if (!skip) for (int j = 0; j < 5; j++) if (n >= 3 * STEP + j * STEP + 2) v[12:5] = step_val(j);
    if (n >= base + 2) v[4] = 1'b0;
    if (n >= base + STEP + 2) v[3] = 1'b1;
    if (n >= base + 2 * STEP + 2) v[2] = 1'b1;
    if (n >= base + 3 * STEP + 2) v[0] = 1'b1;
    return v;
  endfunction

  function automatic logic [12:0] off_exp(input logic [12:0] init, input int n, input int k);
    logic [12:0] v = init;
    int p = STEP;
    if (n >= 2) v[0] = 1'b0;
    if (k % NCO != 0) begin
      if (n >= STEP + 2) v[4] = 1'b1;
      p = 2 * STEP;
    end
    if (n >= p + 2) v[3] = 1'b0;
    if (init[12:5] != 8'hFF && n >= p + STEP + 2) v[12:5] = 8'hFF;
    return v;
  endfunction

  task automatic check_all(input string rq);
    for (int k = 0; k < NCPU; k++)
      chk(dut_snap(k) == model[k], rq, $sformatf("core %0d state", k), dut_snap(k), model[k]);
  endtask

  task automatic do_req(input int cmd, input int cl, input int co, input string rq);
    int k = cl * NCO + co;
    int n, d;
    bit trace_ok = 1'b1;
    logic [12:0] init, e, bad_a = '0, bad_e = '0;
    @(negedge clk);
    req_cmd = 2'(cmd); req_cluster = 1'(cl); req_core = 2'(co); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    n = 1;
    if (co >= NCO || cmd == 3) begin
      chk(err == 1'b1 && busy == 1'b0, "R11", "err pulse / busy", {err, busy}, 2'b10);
      @(negedge clk);
      chk(err == 1'b0 && busy == 1'b0, "R11", "err one cycle", {err, busy}, 0);
      check_all("R11");
      return;
    end
    init = model[k];
    if (cmd == 1) d = on_dur(init);
    else if (cmd == 0) d = off_dur(init, k);
    else begin
      d = 0;
      for (int j = 0; j < NCPU; j++) d += 1 + ((j != k) ? off_dur(model[j], j) : 0);
    end
    forever begin
      if (cmd != 2) begin
        e = (cmd == 1) ? on_exp(init, n) : off_exp(init, n, k);
        if (dut_snap(k) != e && trace_ok) begin trace_ok = 1'b0; bad_a = dut_snap(k); bad_e = e; end
      end
      if (done || n > 4000) break;
      chk(busy == 1'b1, "R9", "busy during sequence", busy, 1);
      @(negedge clk);
      n++;
    end
    chk(n == d + 1, rq, $sformatf("cmd %0d core %0d duration", cmd, k), n - 1, d);
    if (cmd != 2) chk(trace_ok, rq, $sformatf("cmd %0d core %0d step trace", cmd, k), bad_a, bad_e);
    chk(busy == 1'b0, "R10", "busy low with done", busy, 0);
    if (cmd == 1) model[k] = {8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1};
    else
      for (int j = 0; j < NCPU; j++)
        if ((cmd == 0 && j == k) || (cmd == 2 && j != k))
          model[j] = {8'hFF, (j % NCO == 0) ? model[j][4] : 1'b1, 1'b0, model[j][2], model[j][1], 1'b0};
    check_all(rq);
    @(negedge clk);
    chk(done == 1'b0, "R10", "done single cycle", done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    rst_n = 1'b0; req_valid = 1'b0; req_cmd = '0; req_cluster = '0; req_core = '0;
    for (int k = 0; k < NCPU; k++)
      model[k] = (k == 0) ? {8'h00, 5'b01111} : {8'hFF, 5'b10000};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");
    chk({busy, done, err} == 3'b000, "R1", "flags after reset", {busy, done, err}, 0);

    do_req(1, 1, 1, "R3");   // full graded release on core 4
    do_req(1, 1, 1, "R4");   // already powered: no stepping
    do_req(1, 1, 0, "R2");   // core 3 on
    do_req(0, 1, 0, "R7");   // core 0 of cluster 1: no isolation
    do_req(0, 1, 0, "R6");   // already 0xFF
    do_req(0, 1, 1, "R5");
    do_req(1, 0, 2, "R2");
    do_req(2, 0, 2, "R8");   // requester core 2 stays on
    do_req(0, 0, 3, "R11");  // core index out of range
    do_req(3, 0, 1, "R11");  // reserved command

    // R9: request during busy is ignored
    @(negedge clk);
    req_cmd = 2'd1; req_cluster = 1'b0; req_core = 2'd1; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; n = 1;
    repeat (2) begin @(negedge clk); n++; end
    req_cmd = 2'd0; req_cluster = 1'b0; req_core = 2'd0; req_valid = 1'b1;
    @(negedge clk); n++;
    req_valid = 1'b0;
    while (!done && n < 4000) begin @(negedge clk); n++; end
    chk(n == on_dur(model[1]) + 1, "R9", "duration with ignored request", n - 1, on_dur(model[1]));
    model[1] = {8'h00, 5'b01111};
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R9", "no second sequence", busy, 0);
    check_all("R9");

    void'($urandom(32'd7));
    for (int i = 0; i < 30; i++) begin
      int c = $urandom_range(0, 3);
      do_req(c, $urandom_range(0, 1), $urandom_range(0, 3),
             (c == 1) ? "R2" : (c == 0) ? "R5" : "R8");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule